// File: doc/BRIEF.md
# Flash Word Write Assembler

This block takes a stream of single-byte write requests and turns it into aligned 16-bit word writes for a flash programming port. Each request carries a 32-bit byte address, one data byte and a position code that says where the byte sits in a burst. The position code can mark the byte as the opening byte, the closing byte, a lone byte, or one in the middle. An even-addressed byte is held until its odd partner arrives, and the two are then written as one word. A half that no request supplies is written with the erased value FFh. Flash command sequences, erase and program timing are handled elsewhere.

While a burst runs, the block tracks the write mode the flash device must be in. It pulses an entry strobe when a burst opens and an exit strobe, telling the flash to go back to read-array mode, once the closing word has been acknowledged. Every byte after the first is checked against the address the previous byte implies. The burst ends with a response that carries an error code and the number of bytes taken. An error code of zero means success.

Top module: `flash_word_assembler`

## Requirements
- R1: After reset, `req_ready` is 1 and `fl_req`, `wr_mode`, `mode_enter`, `mode_exit` and `rsp_valid` are all 0.
- R2: An even-addressed byte E followed by a byte at address E+1 produces a single word write. That write has `fl_addr` = E, `fl_data[7:0]` = the even byte and `fl_data[15:8]` = the odd byte.
- R3: An odd-addressed byte whose even partner was not the byte just before it is written as a word at the even address below it. Its `fl_data[7:0]` is FFh and its `fl_data[15:8]` is the byte.
- R4: A closing (01h) or lone (02h) byte at an even address is written at once as a word with `fl_data[15:8]` = FFh and `fl_data[7:0]` = the byte.
- R5: Accepting a byte with position code 00h (opening) or 02h (lone) raises `mode_enter` for exactly one cycle, starting in the cycle after acceptance. `wr_mode` goes to 1 in that same cycle.
- R6: After a closing (01h) or lone (02h) byte, `mode_exit` and `rsp_valid` pulse together for one cycle. This happens in the cycle after the acknowledge of that byte's final word write, and `wr_mode` returns to 0 in that cycle.
- R7: Any other position code (for example 03h, 7Eh, FFh) marks a middle byte and changes nothing about the mode: `mode_enter` and `mode_exit` stay 0 and `wr_mode` keeps its level.
- R8: A non-opening byte whose address differs from the previous accepted address plus one sets bit 0 of `rsp_code` for the burst. Any held even byte that is not the new byte's partner is first written out with FFh in its upper half.
- R9: If `fl_err` is 1 in a cycle where `fl_req` and `fl_ack` are both 1, bit 1 of `rsp_code` is set for the burst.
- R10: `rsp_count` gives the number of bytes accepted in the burst. `rsp_code` is 0 when neither error condition occurred.
- R11: While `fl_req` is 1 the block holds `req_ready` at 0, and it keeps `fl_addr` and `fl_data` unchanged until `fl_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Block can take a byte this cycle |
| req_addr | input | 32 | Byte address |
| req_data | input | 8 | Byte value |
| req_flag | input | 8 | Position code: 00h opening, 01h closing, 02h lone, other middle |
| fl_req | output | 1 | Word write request to flash port |
| fl_ack | input | 1 | Flash port takes the current word write |
| fl_err | input | 1 | Flash reports failure, valid with `fl_ack` |
| fl_addr | output | 32 | Word write address (byte address of the even byte) |
| fl_data | output | 16 | Word data, even byte in the low half |
| wr_mode | output | 1 | Flash must be in write mode |
| mode_enter | output | 1 | One-cycle strobe: switch flash into write mode |
| mode_exit | output | 1 | One-cycle strobe: restore read-array mode |
| rsp_valid | output | 1 | Burst response strobe |
| rsp_code | output | 8 | Burst result, 0 on success, bit 0 address mismatch, bit 1 flash error |
| rsp_count | output | 8 | Bytes accepted in the burst |

## Verification
The assertions rely on the flash side raising `fl_ack` only while `fl_req` is high, and on `fl_err` being meaningful only with that acknowledge. They also rely on every burst opening with an opening or lone code before any middle or closing byte arrives. The bench's flash model answers only requests it sees pending, with a delay of zero to two cycles that varies from one write to the next. All streams start each burst with 00h or 02h, and mismatches are made by skipping or jumping addresses inside a burst that is already open.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

   localparam logic [7:0] POS_OPEN  = 8'h00;
   localparam logic [7:0] POS_CLOSE = 8'h01;
   localparam logic [7:0] POS_LONE  = 8'h02;

   localparam int ERR_MM_BIT = 0;
   localparam int ERR_FL_BIT = 1;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FLUSH = 2'd1,
      ST_WORD  = 2'd2
   } fwa_state_e;

   function automatic logic opens_burst(input logic [7:0] pos);
      return (pos == POS_OPEN) || (pos == POS_LONE);
   endfunction

   function automatic logic closes_burst(input logic [7:0] pos);
      return (pos == POS_CLOSE) || (pos == POS_LONE);
   endfunction

endpackage

// File: rtl/fwa_addr_track.sv
module fwa_addr_track #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              opening,
   input  logic [ADDR_W-1:0] addr,
   output logic              mismatch
);
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] next_q;

   assign mismatch = take && !opening && (addr != next_q);

   always_ff @(posedge clk) begin
      if (!rst_n) next_q <= '0;
      else if (take) next_q <= addr + ONE;
   end

endmodule

// File: rtl/fwa_mode_ctl.sv
module fwa_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic open_take,
   input  logic burst_done,
   output logic wr_mode,
   output logic mode_enter,
   output logic mode_exit
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_mode    <= 1'b0;
         mode_enter <= 1'b0;
         mode_exit  <= 1'b0;
      end else begin
         mode_enter <= open_take;
         mode_exit  <= burst_done;
         if (open_take) wr_mode <= 1'b1;
         else if (burst_done) wr_mode <= 1'b0;
      end
   end

   // R6
   exit_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> mode_exit && !mode_enter);

endmodule

// File: rtl/fwa_status.sv
module fwa_status #(
   parameter int CNT_W  = 8,
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              opening,
   input  logic              mismatch,
   input  logic              ack_err,
   input  logic              burst_done,
   output logic              rsp_valid,
   output logic [CODE_W-1:0] rsp_code,
   output logic [CNT_W-1:0]  rsp_count
);
   import fwa_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CODE_W < 2) begin : g_code_w_bad
      $error("fwa_status: CODE_W must hold both error bits");
   end

   logic [CODE_W-1:0] err_q;
   logic [CODE_W-1:0] err_now;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      err_now = err_q;
      if (mismatch) err_now[ERR_MM_BIT] = 1'b1;
      if (ack_err)  err_now[ERR_FL_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q     <= '0;
         cnt_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_code  <= '0;
         rsp_count <= '0;
      end else begin
         rsp_valid <= burst_done;
         if (take && opening) begin
            err_q <= '0;
            cnt_q <= CNT_ONE;
         end else begin
            err_q <= err_now;
            if (take && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
         end
         if (burst_done) begin
            rsp_code  <= err_now;
            rsp_count <= cnt_q;
         end
      end
   end

   // R10
   count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_count != '0);

endmodule

// File: rtl/flash_word_assembler.sv
module flash_word_assembler #(
   parameter int          ADDR_W    = 32,
   parameter int          CNT_W     = 8,
   parameter int          CODE_W    = 8,
   parameter logic [7:0]  FILL_BYTE = 8'hFF,
   parameter bit          WORD_ADDR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic [7:0]        req_flag,
   output logic              fl_req,
   input  logic              fl_ack,
   input  logic              fl_err,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [15:0]       fl_data,
   output logic              wr_mode,
   output logic              mode_enter,
   output logic              mode_exit,
   output logic              rsp_valid,
   output logic [CODE_W-1:0] rsp_code,
   output logic [CNT_W-1:0]  rsp_count
);
   import fwa_pkg::*;

   localparam int WA_W = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_addr_w_bad
      $error("flash_word_assembler: ADDR_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_cnt_w_bad
      $error("flash_word_assembler: CNT_W must be positive");
   end

   fwa_state_e st_q;

   logic            pend_v_q;
   logic [WA_W-1:0] pend_wa_q;
   logic [7:0]      pend_d_q;

   logic [ADDR_W-1:0] def_addr_q;
   logic [7:0]        def_data_q;
   logic              def_end_q;

   logic            cur_end_q;
   logic [WA_W-1:0] wa_q;
   logic [15:0]     wd_q;
   logic            fl_req_q;

   logic take, in_open, in_close, partner, need_flush;
   logic mismatch, burst_done, ack_err;

   logic [ADDR_W-1:0] b_addr;
   logic [7:0]        b_data;
   logic              b_end, b_partner, b_issue;
   logic [15:0]       b_word;

   assign req_ready  = (st_q == ST_IDLE);
   assign take       = req_valid && req_ready;
   assign in_open    = opens_burst(req_flag);
   assign in_close   = closes_burst(req_flag);
   assign partner    = pend_v_q && req_addr[0] && (req_addr[ADDR_W-1:1] == pend_wa_q);
   assign need_flush = pend_v_q && !partner;

   // Byte under placement: incoming byte when idle, parked byte after a flush.
   always_comb begin
      if (st_q == ST_FLUSH) begin
         b_addr    = def_addr_q;
         b_data    = def_data_q;
         b_end     = def_end_q;
         b_partner = 1'b0;
      end else begin
         b_addr    = req_addr;
         b_data    = req_data;
         b_end     = in_close;
         b_partner = partner;
      end
      b_issue = b_addr[0] || b_end;
      if (b_addr[0]) b_word = {b_data, (b_partner ? pend_d_q : FILL_BYTE)};
      else           b_word = {FILL_BYTE, b_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pend_v_q   <= 1'b0;
         pend_wa_q  <= '0;
         pend_d_q   <= '0;
         def_addr_q <= '0;
         def_data_q <= '0;
         def_end_q  <= 1'b0;
         cur_end_q  <= 1'b0;
         wa_q       <= '0;
         wd_q       <= '0;
         fl_req_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  if (need_flush) begin
                     fl_req_q   <= 1'b1;
                     wa_q       <= pend_wa_q;
                     wd_q       <= {FILL_BYTE, pend_d_q};
                     pend_v_q   <= 1'b0;
                     def_addr_q <= req_addr;
                     def_data_q <= req_data;
                     def_end_q  <= in_close;
                     st_q       <= ST_FLUSH;
                  end else if (b_issue) begin
                     fl_req_q  <= 1'b1;
                     wa_q      <= b_addr[ADDR_W-1:1];
                     wd_q      <= b_word;
                     pend_v_q  <= 1'b0;
                     cur_end_q <= b_end;
                     st_q      <= ST_WORD;
                  end else begin
                     pend_v_q  <= 1'b1;
                     pend_wa_q <= b_addr[ADDR_W-1:1];
                     pend_d_q  <= b_data;
                  end
               end
            end
            ST_FLUSH: begin
               if (fl_ack) begin
                  if (b_issue) begin
                     wa_q      <= b_addr[ADDR_W-1:1];
                     wd_q      <= b_word;
                     cur_end_q <= b_end;
                     st_q      <= ST_WORD;
                  end else begin
                     fl_req_q  <= 1'b0;
                     pend_v_q  <= 1'b1;
                     pend_wa_q <= b_addr[ADDR_W-1:1];
                     pend_d_q  <= b_data;
                     st_q      <= ST_IDLE;
                  end
               end
            end
            ST_WORD: begin
               if (fl_ack) begin
                  fl_req_q <= 1'b0;
                  st_q     <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign fl_req     = fl_req_q;
   assign fl_data    = wd_q;
   assign burst_done = (st_q == ST_WORD) && fl_ack && cur_end_q;
   assign ack_err    = fl_req_q && fl_ack && fl_err;

   if (WORD_ADDR) begin : g_word_index
      assign fl_addr = {1'b0, wa_q};
   end else begin : g_byte_addr
      assign fl_addr = {wa_q, 1'b0};
   end

   fwa_addr_track #(.ADDR_W(ADDR_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .opening  (in_open),
      .addr     (req_addr),
      .mismatch (mismatch)
   );

   fwa_mode_ctl u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_take  (take && in_open),
      .burst_done (burst_done),
      .wr_mode    (wr_mode),
      .mode_enter (mode_enter),
      .mode_exit  (mode_exit)
   );

   fwa_status #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .opening    (in_open),
      .mismatch   (mismatch),
      .ack_err    (ack_err),
      .burst_done (burst_done),
      .rsp_valid  (rsp_valid),
      .rsp_code   (rsp_code),
      .rsp_count  (rsp_count)
   );

   // R11
   fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_data));

   // R11
   ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> !req_ready);

   // R6
   exit_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_exit |-> rsp_valid && !wr_mode);

   // R5
   enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_enter |-> wr_mode && !mode_exit);

endmodule

// File: tb/flash_word_assembler_bench.sv
`timescale 1ns/1ps
module flash_word_assembler_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic [7:0]  req_data;
   logic [7:0]  req_flag;
   logic        fl_req;
   logic        fl_ack;
   logic        fl_err;
   logic [31:0] fl_addr;
   logic [15:0] fl_data;
   logic        wr_mode, mode_enter, mode_exit, rsp_valid;
   logic [7:0]  rsp_code;
   logic [7:0]  rsp_count;

   always #2.5 clk = ~clk;

   flash_word_assembler u_flash_word_assembler (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_flag(req_flag),
      .fl_req(fl_req), .fl_ack(fl_ack), .fl_err(fl_err),
      .fl_addr(fl_addr), .fl_data(fl_data),
      .wr_mode(wr_mode), .mode_enter(mode_enter), .mode_exit(mode_exit),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count)
   );

   int checks = 0;
   int failures = 0;
   bit started = 0;
   bit done_flag = 0;

   // Reference model state
   logic [47:0] exp_wr[$];
   string       exp_tag[$];
   logic [15:0] exp_rsp[$];
   bit          m_pv = 0;
   logic [31:0] m_pa = '0;
   logic [7:0]  m_pd = '0;
   logic [31:0] m_next = '0;
   bit          m_mm = 0;
   bit          m_fe = 0;
   int          m_cnt = 0;

   bit drv_acc = 0;
   bit drv_open = 0;
   bit ref_mode = 0;
   int dly = 0;
   int pat = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   function automatic bit err_addr(input logic [31:0] a);
      return a[31:1] == 31'h300;
   endfunction

   task automatic push_wr(input logic [31:0] a, input logic [15:0] w, input string tag);
      exp_wr.push_back({a, w});
      exp_tag.push_back(tag);
      if (err_addr(a)) m_fe = 1;
   endtask

   task automatic model_byte(input logic [31:0] a, input logic [7:0] d, input logic [7:0] f);
      bit opn, cls, part;
      opn = (f == 8'h00) || (f == 8'h02);
      cls = (f == 8'h01) || (f == 8'h02);
      if (opn) begin m_mm = 0; m_fe = 0; m_cnt = 0; end
      else if (a != m_next) m_mm = 1;
      m_cnt++;
      m_next = a + 1;
      part = m_pv && a[0] && (a[31:1] == m_pa[31:1]);
      if (m_pv && !part) begin
         push_wr(m_pa, {8'hFF, m_pd}, "R8");
         m_pv = 0;
      end
      if (a[0]) begin
         push_wr({a[31:1], 1'b0}, {d, (m_pv ? m_pd : 8'hFF)}, m_pv ? "R2" : "R3");
         m_pv = 0;
      end else if (cls) begin
         push_wr(a, {8'hFF, d}, "R4");
      end else begin
         m_pv = 1; m_pa = a; m_pd = d;
      end
      if (cls) exp_rsp.push_back({6'd0, m_fe, m_mm, 8'(m_cnt)});
   endtask

   task automatic send(input logic [31:0] a, input logic [7:0] d, input logic [7:0] f);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_data = d; req_flag = f;
      model_byte(a, d, f);
      while (!req_ready) @(negedge clk);
      drv_open = (f == 8'h00) || (f == 8'h02);
      drv_acc = 1;
      @(posedge clk);
      #1 req_valid = 0;
   endtask

   // Flash port model: acknowledge after a varying delay, compare each write.
   always @(negedge clk) begin
      if (fl_ack) begin
         fl_ack = 0; fl_err = 0;
         pat = (pat + 1) % 3;
         dly = pat;
      end else if (rst_n && fl_req) begin
         if (dly == 0) begin
            fl_ack = 1;
            fl_err = err_addr(fl_addr);
            if (exp_wr.size() == 0) begin
               chk(0, "R2", {fl_addr, fl_data}, 64'h0);
            end else begin
               logic [47:0] e;
               string t;
               e = exp_wr.pop_front();
               t = exp_tag.pop_front();
               chk({fl_addr, fl_data} == e, t, {fl_addr, fl_data}, e);
            end
         end else dly--;
      end
   end

   // Per-cycle comparison against the reference mode/response model.
   always @(posedge clk) begin
      #2;
      if (started && rst_n) begin
         bit exp_enter;
         exp_enter = drv_acc && drv_open;
         if (drv_acc && !drv_open)
            chk(mode_enter == 1'b0, "R7", mode_enter, 0);
         else
            chk(mode_enter == exp_enter, "R5", mode_enter, exp_enter);
         drv_acc = 0;
         if (exp_enter) ref_mode = 1;
         chk(mode_exit == rsp_valid, "R6", mode_exit, rsp_valid);
         chk(req_ready == !fl_req, "R11", req_ready, !fl_req);
         if (rsp_valid) begin
            ref_mode = 0;
            if (exp_rsp.size() == 0) chk(0, "R6", rsp_valid, 0);
            else begin
               logic [15:0] r;
               r = exp_rsp.pop_front();
               chk(rsp_count == r[7:0], "R10", rsp_count, r[7:0]);
               chk(rsp_code == r[15:8], r[9] ? "R9" : (r[8] ? "R8" : "R10"), rsp_code, r[15:8]);
            end
         end
         chk(wr_mode == ref_mode, ref_mode ? "R5" : "R6", wr_mode, ref_mode);
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!done_flag) begin
         chk(0, "watchdog", 0, 1);
         finish_run();
      end
   end

   initial begin
      rst_n = 0; req_valid = 0; req_addr = '0; req_data = '0; req_flag = '0;
      fl_ack = 0; fl_err = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1, "R1", req_ready, 1);
      chk(fl_req == 0, "R1", fl_req, 0);
      chk(wr_mode == 0, "R1", wr_mode, 0);
      chk(rsp_valid == 0 && mode_enter == 0 && mode_exit == 0, "R1",
          {rsp_valid, mode_enter, mode_exit}, 0);
      started = 1;

      // R2: aligned burst, pairs
      send(32'h100, 8'h11, 8'h00); send(32'h101, 8'h22, 8'h7E);
      send(32'h102, 8'h33, 8'h03); send(32'h103, 8'h44, 8'h01);
      // R4: lone even byte; R3: lone odd byte
      send(32'h200, 8'h55, 8'h02);
      send(32'h201, 8'h66, 8'h02);
      // R3/R4: odd start, even end
      send(32'h301, 8'hA1, 8'h00); send(32'h302, 8'hA2, 8'hFF);
      send(32'h303, 8'hA3, 8'h7E); send(32'h304, 8'hA4, 8'h01);
      // R8: jump to odd address
      send(32'h400, 8'hB0, 8'h00); send(32'h401, 8'hB1, 8'h05);
      send(32'h405, 8'hB5, 8'h01);
      // R8: skip leaves a held even byte flushed
      send(32'h500, 8'hC0, 8'h00); send(32'h502, 8'hC2, 8'h01);
      // R8: skip inside a burst with a middle even byte held
      send(32'h510, 8'hC4, 8'h00); send(32'h511, 8'hC5, 8'h7E);
      send(32'h512, 8'hC6, 8'h7E); send(32'h516, 8'hC7, 8'h7E);
      send(32'h517, 8'hC8, 8'h01);
      // R9: flash error
      send(32'h600, 8'hD0, 8'h00); send(32'h601, 8'hD1, 8'h01);
      // R8 + R9 together
      send(32'h600, 8'hE0, 8'h00); send(32'h603, 8'hE3, 8'h01);
      // Long burst with mixed middle codes, R7
      for (int i = 0; i < 20; i++) begin
         logic [7:0] f;
         if (i == 0) f = 8'h00;
         else if (i == 19) f = 8'h01;
         else if (i % 3 == 0) f = 8'h03;
         else if (i % 3 == 1) f = 8'h7E;
         else f = 8'hFF;
         send(32'h1000 + i, 8'(i * 13 + 5), f);
      end

      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (exp_wr.size() == 0 && exp_rsp.size() == 0 && req_ready && !fl_req) break;
      end
      repeat (5) @(negedge clk);
      chk(exp_wr.size() == 0, "R2", exp_wr.size(), 0);
      chk(exp_rsp.size() == 0, "R6", exp_rsp.size(), 0);
      chk(wr_mode == 0, "R6", wr_mode, 0);
      done_flag = 1;
      finish_run();
   end

endmodule